// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Mask Unit

This block gathers the event sources of an I2C bus master into one status register and drives a single level interrupt toward the processor. Each source has a fixed bit. Software clears bits by writing ones, and a mask register of the same layout chooses which set bits assert the interrupt. Six of the sources arrive as one-cycle pulses and are held until cleared. The two data-request sources are levels that report the present FIFO threshold state, so they set again as long as their condition stays true.

A build parameter decides how the packet-done event is treated. In the maskable build, that event follows its mask bit like any other source. In the fixed build, the packet-done bit always asserts the interrupt, whatever its mask bit holds. The event sources are outside this unit.

Top module: `i2c_irq_collect`

## Requirements
- R1: Status bits are fixed to these positions: 7 packet done, 6 all packets done, 5 transmit FIFO overflow, 4 receive FIFO underflow, 3 missing acknowledge, 2 arbitration lost, 1 transmit data request, 0 receive data request. `pktEvt`[5:0] drives bits 7..2 in that order, and `dataReq`[1:0] drives bits 1..0. A set bit stays set until it is cleared.
- R2: A write with `regSel`=0 targets status. Each 1 in `wrData` clears that status bit. Each 0 leaves its bit as it was.
- R3: A write with `regSel`=1 loads the mask from `wrData`. The mask has the same bit layout as status, and 1 enables a source. Reset sets the mask to all zeros, and the mask changes only through such a write.
- R4: After reset, status is 0, mask is 0 and `irq` is low.
- R5: With `PKT_MASKABLE`=0, a set packet-done bit (bit 7) asserts `irq` even when mask bit 7 is 0. With `PKT_MASKABLE`=1, mask bit 7 gates that bit.
- R6: Clearing a data-request bit while its `dataReq` level is still high leaves the bit set. Once the level is low, a clear removes the bit.
- R7: If a source sets a bit in the same cycle that a write clears it, the bit stays set.
- R8: `irq` is a register that holds the OR of (status AND effective mask) from the previous cycle.
- R9: Reading the outputs has no side effects, and a mask write leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pktEvt | input | 6 | Event pulses for status bits 7..2 |
| dataReq | input | 2 | Data-request levels for status bits 1..0 |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Write target: 0 status (clear), 1 mask |
| wrData | input | 8 | Write data |
| statusOut | output | 8 | Current status register |
| maskOut | output | 8 | Current mask register |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds two instances side by side and drives them with the same stimulus. One uses `PKT_MASKABLE`=1 and the other uses `PKT_MASKABLE`=0. Their `irq` outputs differ only when the packet-done bit is set and its mask bit is clear. This makes both treatments of that event visible in the same cycles. Both builds use the default `REQ_BITS`=2, so the level-fed data-request bits can be checked for set-again behaviour beside the sticky pulse-fed bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int EVT_W = 8;
  localparam int PKT_DONE_BIT = 7;

  typedef logic [EVT_W-1:0] evtVec_t;

  // strobes passed from the write decoder to the register datapath
  typedef struct packed {
    evtVec_t clrBits;
    logic    maskLoad;
    evtVec_t maskBits;
  } regStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic       wrEn,
  input  logic       regSel,
  input  evtVec_t    wrData,
  output regStrobe_t strobe
);
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_MASK   = 1'b1;

  always_comb begin
    strobe.clrBits  = '0;
    strobe.maskLoad = 1'b0;
    strobe.maskBits = wrData;
    if (wrEn) begin
      if (regSel == SEL_STATUS) strobe.clrBits = wrData;
      if (regSel == SEL_MASK)   strobe.maskLoad = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter bit PKT_MASKABLE = 1'b1
)(
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strobe,
  input  evtVec_t    setBits,
  output evtVec_t    statusQ,
  output evtVec_t    maskQ,
  output logic       irqQ
);
  evtVec_t effMask;

  generate
    if (PKT_MASKABLE) begin : g_gated
      assign effMask = maskQ;
    end else begin : g_forced
      localparam evtVec_t FORCE = evtVec_t'(1) << PKT_DONE_BIT;
      assign effMask = maskQ | FORCE;
    end
  endgenerate

  // a source that sets a bit wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~strobe.clrBits) | setBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                maskQ <= '0;
    else if (strobe.maskLoad) maskQ <= strobe.maskBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusQ & effMask);
  end

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobe.clrBits & ~setBits)) |=> ((statusQ & $past(strobe.clrBits & ~setBits)) == '0)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|setBits) |=> ((statusQ & $past(setBits)) == $past(setBits))); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((statusQ ^ $past(statusQ)) & ~$past(setBits | strobe.clrBits)) == '0)); // R1
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.maskLoad |=> $stable(maskQ)); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == '0) |=> !irqQ); // R8

  generate
    if (!PKT_MASKABLE) begin : g_pkt_chk
      AST_PKT_FORCED: assert property (@(posedge clk) disable iff (!rstN)
        statusQ[PKT_DONE_BIT] |=> irqQ); // R5
    end
  endgenerate
endmodule

// File: rtl/i2c_irq_collect.sv
module i2c_irq_collect
  import irqc_pkg::*;
#(
  parameter bit PKT_MASKABLE = 1'b1,
  parameter int REQ_BITS     = 2,
  localparam int PULSE_W     = EVT_W - REQ_BITS
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PULSE_W-1:0] pktEvt,
  input  logic [REQ_BITS-1:0] dataReq,
  input  logic               wrEn,
  input  logic               regSel,
  input  logic [EVT_W-1:0]   wrData,
  output logic [EVT_W-1:0]   statusOut,
  output logic [EVT_W-1:0]   maskOut,
  output logic               irq
);
  regStrobe_t strobe;
  evtVec_t    setBits;

  assign setBits = {pktEvt, dataReq};

  irqc_ctrl u_ctrl (
    .wrEn   (wrEn),
    .regSel (regSel),
    .wrData (wrData),
    .strobe (strobe)
  );

  irqc_datapath #(.PKT_MASKABLE(PKT_MASKABLE)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .setBits (setBits),
    .statusQ (statusOut),
    .maskQ   (maskOut),
    .irqQ    (irq)
  );
endmodule

// File: tb/i2c_irq_collect_bench.sv
`timescale 1ns/1ps
module i2c_irq_collect_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN;
  logic [5:0] evt;
  logic [1:0] req;
  logic       wrEn, regSel;
  logic [7:0] wrData;
  logic [7:0] stA, mkA, stB, mkB;
  logic       irqA, irqB;

  i2c_irq_collect #(.PKT_MASKABLE(1'b1)) u_i2c_irq_collect (
    .clk(clk), .rstN(rstN), .pktEvt(evt), .dataReq(req), .wrEn(wrEn),
    .regSel(regSel), .wrData(wrData), .statusOut(stA), .maskOut(mkA), .irq(irqA));

  i2c_irq_collect #(.PKT_MASKABLE(1'b0)) u_i2c_irq_collect_fixed (
    .clk(clk), .rstN(rstN), .pktEvt(evt), .dataReq(req), .wrEn(wrEn),
    .regSel(regSel), .wrData(wrData), .statusOut(stB), .maskOut(mkB), .irq(irqB));

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] eSt, eMk;
  logic eIrqA, eIrqB;

  function automatic logic irqOf(input logic [7:0] st, input logic [7:0] mk, input bit forcePkt);
    return |(st & (forcePkt ? (mk | 8'h80) : mk));
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " status"}, stA, eSt);
    chk({tag, " status(fixed)"}, stB, eSt);
    chk({tag, " mask"}, mkA, eMk);
    chk({tag, " mask(fixed)"}, mkB, eMk);
    chk({tag, " irq"}, {7'd0, irqA}, {7'd0, eIrqA});
    chk({tag, " irq(fixed)"}, {7'd0, irqB}, {7'd0, eIrqB});
  endtask

  // drive at a falling edge, model one rising edge, check at next falling edge
  task automatic cyc(input logic [5:0] e, input logic [1:0] r, input logic we,
                     input logic ws, input logic [7:0] wd, input string tag);
    logic [7:0] clr;
    evt = e; req = r; wrEn = we; regSel = ws; wrData = wd;
    clr = (we && !ws) ? wd : 8'h00;
    eIrqA = irqOf(eSt, eMk, 1'b0);
    eIrqB = irqOf(eSt, eMk, 1'b1);
    eSt = (eSt & ~clr) | {e, r};
    if (we && ws) eMk = wd;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R8 watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; evt = '0; req = '0; wrEn = 1'b0; regSel = 1'b0; wrData = '0;
    eSt = '0; eMk = '0; eIrqA = 1'b0; eIrqB = 1'b0;
    repeat (3) @(negedge clk);
    checkAll("R4 reset");
    rstN = 1'b1;

    // R1: each source sets its own bit, then hold and clear
    for (int i = 0; i < 8; i++) begin
      logic [7:0] one;
      one = 8'h01 << i;
      cyc(one[7:2], one[1:0], 1'b0, 1'b0, 8'h00, "R1 set bit");
      cyc(6'd0, 2'd0, 1'b0, 1'b0, 8'h00, "R1 sticky hold");
      cyc(6'd0, 2'd0, 1'b1, 1'b0, one, "R2 clear bit");
    end

    // R5: packet done with mask clear
    cyc(6'b100000, 2'd0, 1'b0, 1'b0, 8'h00, "R5 pkt set");
    cyc(6'd0, 2'd0, 1'b0, 1'b0, 8'h00, "R5 pkt irq unmasked");
    cyc(6'd0, 2'd0, 1'b1, 1'b1, 8'h80, "R5 mask pkt");
    cyc(6'd0, 2'd0, 1'b0, 1'b0, 8'h00, "R5 pkt irq masked");

    // R2: writing zeros changes nothing
    cyc(6'b001111, 2'd0, 1'b0, 1'b0, 8'h00, "R1 multi set");
    cyc(6'd0, 2'd0, 1'b1, 1'b0, 8'h00, "R2 write zeros");
    cyc(6'd0, 2'd0, 1'b1, 1'b0, 8'h30, "R2 partial clear");

    // R9: mask write does not touch status
    cyc(6'd0, 2'd0, 1'b1, 1'b1, 8'h08, "R9 mask write");
    cyc(6'd0, 2'd0, 1'b0, 1'b0, 8'h00, "R8 irq by mask");

    // R7: set and clear together
    cyc(6'b000010, 2'd0, 1'b1, 1'b0, 8'hFF, "R7 set beats clear");
    cyc(6'd0, 2'd0, 1'b0, 1'b0, 8'h00, "R7 hold");

    // R6: level request persists through clears
    cyc(6'd0, 2'b11, 1'b1, 1'b0, 8'hFF, "R6 req while clear");
    cyc(6'd0, 2'b11, 1'b1, 1'b0, 8'h03, "R6 req reasserts");
    cyc(6'd0, 2'b00, 1'b1, 1'b0, 8'h03, "R6 req dropped clear");
    cyc(6'd0, 2'b00, 1'b0, 1'b0, 8'h00, "R6 req gone");

    // R8: constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] e;
      logic [1:0] r;
      logic we, ws;
      logic [7:0] wd;
      e  = (($urandom % 4) == 0) ? 6'($urandom) & 6'($urandom) : 6'd0;
      r  = (($urandom % 3) == 0) ? 2'($urandom) : 2'd0;
      we = (($urandom % 3) == 0);
      ws = (($urandom % 4) == 0);
      wd = 8'($urandom);
      cyc(e, r, we, ws, wd, "R8 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule